// File: doc/BRIEF.md
# I2C Slave Own-Address Match Unit

This block sits behind the bit-level receiver of an I2C slave. It holds one byte of own-address state: a seven-bit slave address in the upper bits and a direction bit in the least significant bit. A CPU loads it through a simple write strobe and can read it back. After the bus front end reports a START condition, the first complete byte it delivers is compared with the stored address. The result is a registered match flag. The flag holds for the rest of the transfer and clears at the next START or STOP.

A mode input selects how the compare works. With seven-bit addressing, only the upper seven bits take part, and the direction bit on both sides is ignored. With ten-bit addressing, the first header byte must equal all eight stored bits, including the direction bit. Each STOP clears the stored direction bit, and this clear has priority over a CPU write made in the same cycle. The acknowledge bit and the second byte of a ten-bit address are handled elsewhere.

Top module: `slave_addr_match`

## Requirements
- R1: After reset, `own_addr` reads 0x00 and `match` is 0. A `wr_en` pulse with no STOP loads all of `wr_data` into `own_addr`, and the new value is visible on the cycle after the write. Bits 7..1 hold the slave address (bit 7 is the most significant), and bit 0 is the direction bit.
- R2: A byte strobe (`rx_valid`) that arrives before any START since reset, or after a STOP with no START since, leaves `match` at 0.
- R3: With `mode_10b` = 0, the first byte after START matches when `rx_byte[7:1]` equals `own_addr[7:1]`. Bit 0 of both the byte and the register has no effect on the result.
- R4: With `mode_10b` = 1, the first byte after START matches only when all eight bits of `rx_byte` equal `own_addr`, including bit 0.
- R5: A `stop_det` pulse clears `own_addr[0]` from the next cycle and leaves bits 7..1 unchanged.
- R6: When `wr_en` and `stop_det` fall in the same cycle, bits 7..1 take `wr_data[7:1]` and bit 0 becomes 0.
- R7: `match` takes the compare result on the cycle after the first byte strobe following START. It then holds that value.
- R8: `match` is 0 on the cycle after any `start_det` or `stop_det` pulse.
- R9: Byte strobes after the first byte following START do not change `match` until another START arrives.
- R10: A byte strobe in the same cycle as `start_det` is not compared. The next strobe is the one compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_10b | input | 1 | 1 selects ten-bit addressing, 0 selects seven-bit |
| start_det | input | 1 | One-cycle pulse: START condition seen |
| stop_det | input | 1 | One-cycle pulse: STOP condition seen |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | ADDR_W+1 | Received byte, direction bit in bit 0 |
| wr_en | input | 1 | CPU write strobe for the own-address register |
| wr_data | input | ADDR_W+1 | CPU write data |
| own_addr | output | ADDR_W+1 | Current own-address register contents |
| match | output | 1 | Registered address match flag for the current transfer |

## Verification
The bench uses the default ADDR_W of 7, which gives the standard eight-bit header layout. Every bit of the address and the direction bit can therefore be driven directly. This lets the vector table place a difference only in bit 0 and show that it is ignored in seven-bit mode but decisive in ten-bit mode. It also puts a ten-bit header pattern beside an all-zero address. The directed tests cover the cycles where a START meets a byte strobe and where a write meets a STOP.

// File: rtl/sam_pkg.sv
package sam_pkg;
  // Layout of the own-address byte: slave address above, direction bit at 0.
  localparam int DIR_BIT = 0;

  typedef enum logic {
    ADDR_MODE_7  = 1'b0,
    ADDR_MODE_10 = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/sam_own_reg.sv
module sam_own_reg #(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stop_det,
  output logic [BYTE_W-1:0] q
);
  import sam_pkg::*;

  logic [BYTE_W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else begin
      if (wr_en) q_r <= wr_data;
      // Hardware clear of the direction bit overrides the CPU write.
      if (stop_det) q_r[DIR_BIT] <= 1'b0;
    end
  end

  assign q = q_r;

  // R5
  stop_clears_dir_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (q_r[DIR_BIT] == 1'b0));

  // R6
  write_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (q_r[BYTE_W-1:1] == $past(wr_data[BYTE_W-1:1])));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !stop_det) |=> $stable(q_r));
endmodule

// File: rtl/sam_arm_tracker.sv
module sam_arm_tracker (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_det,
  input  logic rx_valid,
  output logic armed,
  output logic take_byte
);
  logic armed_r;

  // The compare window is the first byte strobe after START.
  assign take_byte = armed_r && rx_valid && !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (rst)            armed_r <= 1'b0;
    else if (start_det) armed_r <= 1'b1;
    else if (stop_det)  armed_r <= 1'b0;
    else if (rx_valid)  armed_r <= 1'b0;
  end

  assign armed = armed_r;

  // R9
  single_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_r && rx_valid && !start_det) |=> !armed_r);

  // R10
  start_rearms_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> armed_r);
endmodule

// File: rtl/sam_compare.sv
module sam_compare #(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              mode_10b,
  input  logic [BYTE_W-1:0] own,
  input  logic [BYTE_W-1:0] rx,
  output logic              hit
);
  import sam_pkg::*;

  logic [BYTE_W-1:0] bit_ok;

  generate
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      if (i == DIR_BIT) begin : g_dir
        // The direction bit counts only with ten-bit headers.
        assign bit_ok[i] = (addr_mode_e'(mode_10b) == ADDR_MODE_7) || (own[i] == rx[i]);
      end else begin : g_addr
        assign bit_ok[i] = (own[i] == rx[i]);
      end
    end
  endgenerate

  assign hit = &bit_ok;
endmodule

// File: rtl/slave_addr_match.sv
module slave_addr_match #(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_10b,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] own_addr,
  output logic              match
);
  logic [BYTE_W-1:0] own_q;
  logic              armed;
  logic              take_byte;
  logic              hit;
  logic              match_r;

  sam_own_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .stop_det (stop_det),
    .q        (own_q)
  );

  sam_arm_tracker u_arm (
    .clk       (clk),
    .rst       (rst),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rx_valid  (rx_valid),
    .armed     (armed),
    .take_byte (take_byte)
  );

  sam_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .mode_10b (mode_10b),
    .own      (own_q),
    .rx       (rx_byte),
    .hit      (hit)
  );

  always_ff @(posedge clk) begin
    if (rst)                        match_r <= 1'b0;
    else if (start_det || stop_det) match_r <= 1'b0;
    else if (take_byte)             match_r <= hit;
  end

  assign own_addr = own_q;
  assign match    = match_r;

  // R8
  bus_event_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> !match_r);

  // R2
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(match_r) |-> $past(armed && rx_valid));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_det && !stop_det && !(armed && rx_valid)) |=> $stable(match_r));
endmodule

// File: tb/slave_addr_match_test.sv
module slave_addr_match_test;
  localparam int ADDR_W = 7;
  localparam int BW = ADDR_W + 1;

  logic clk = 1'b0;
  logic rst;
  logic mode_10b, start_det, stop_det, rx_valid, wr_en;
  logic [BW-1:0] rx_byte, wr_data;
  logic [BW-1:0] own_addr;
  logic match;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slave_addr_match #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .mode_10b(mode_10b), .start_det(start_det),
    .stop_det(stop_det), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_en(wr_en), .wr_data(wr_data), .own_addr(own_addr), .match(match)
  );

  // {mode, own address, received byte, expected match}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 8'hA0, 8'hA1, 1'b1},
    {1'b0, 8'hA1, 8'hA0, 1'b1},
    {1'b0, 8'hA0, 8'hA2, 1'b0},
    {1'b1, 8'hF1, 8'hF1, 1'b1},
    {1'b1, 8'hF1, 8'hF0, 1'b0},
    {1'b1, 8'hF0, 8'hF0, 1'b1},
    {1'b0, 8'h00, 8'h01, 1'b1},
    {1'b1, 8'hFE, 8'h7E, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
    start_det = 0; stop_det = 0; rx_valid = 0; wr_en = 0;
  endtask

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_own(input logic [BW-1:0] v);
    wr_en = 1; wr_data = v; tick();
  endtask
  task automatic do_start(); start_det = 1; tick(); endtask
  task automatic do_stop();  stop_det = 1;  tick(); endtask
  task automatic send(input logic [BW-1:0] b);
    rx_valid = 1; rx_byte = b; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-reqs actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; mode_10b = 0; start_det = 0; stop_det = 0; rx_valid = 0;
    wr_en = 0; rx_byte = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1 own_addr reset", own_addr, 8'h00);
    chk("R1 match reset", {7'b0, match}, 8'h00);

    // R2 byte before any START
    send(8'h00);
    chk("R2 no start no match", {7'b0, match}, 8'h00);

    // Table walk: R3 / R4 / R7
    for (int i = 0; i < NV; i++) begin
      mode_10b = VEC[i][17];
      write_own(VEC[i][16:9]);
      chk("R1 write readback", own_addr, VEC[i][16:9]);
      do_start();
      send(VEC[i][8:1]);
      chk(VEC[i][17] ? "R4 ten-bit compare" : "R3 seven-bit compare",
          {7'b0, match}, {7'b0, VEC[i][0]});
      do_stop();
    end

    // R9: later bytes ignored, hit case then miss case
    mode_10b = 0;
    write_own(8'h6C);
    do_start(); send(8'h6D);
    chk("R7 match after first byte", {7'b0, match}, 8'h01);
    send(8'h12);
    chk("R9 later byte keeps hit", {7'b0, match}, 8'h01);
    // R8 START clears
    do_start();
    chk("R8 start clears", {7'b0, match}, 8'h00);
    send(8'h12);
    chk("R3 miss", {7'b0, match}, 8'h00);
    send(8'h6C);
    chk("R9 later byte no hit", {7'b0, match}, 8'h00);
    do_start(); send(8'h6C);
    chk("R7 rematch", {7'b0, match}, 8'h01);
    do_stop();
    chk("R8 stop clears", {7'b0, match}, 8'h00);
    // R2 byte after STOP without START
    send(8'h6C);
    chk("R2 after stop no compare", {7'b0, match}, 8'h00);

    // R5 STOP clears direction bit only
    write_own(8'hA5);
    chk("R1 write A5", own_addr, 8'hA5);
    do_stop();
    chk("R5 stop clears bit0", own_addr, 8'hA4);

    // R6 write and STOP together
    wr_en = 1; wr_data = 8'h5B; stop_det = 1; tick();
    chk("R6 write+stop", own_addr, 8'h5A);

    // R10 byte in START cycle not compared; ten-bit, bit0 matters
    mode_10b = 1;
    write_own(8'hF3);
    start_det = 1; rx_valid = 1; rx_byte = 8'hF3; tick();
    chk("R10 start-cycle byte ignored", {7'b0, match}, 8'h00);
    send(8'hF3);
    chk("R10 next byte compared", {7'b0, match}, 8'h01);
    do_stop();
    // R4 bit0 now cleared by STOP: header with bit0=1 misses
    do_start(); send(8'hF3);
    chk("R4 cleared dir bit misses", {7'b0, match}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule